// File: doc/BRIEF.md
# Dual-Mode Timer Counter Core

This block is an up-counting timer of configurable width (32 bits by default) clocked by a functional clock. Software, or a bus adapter in front of it, writes a small set of registers through a single-cycle write port: a control word, a reload value, the live count, a compare value, a reload trigger, a write-one-to-clear event status, interrupt enable set and clear, and a wakeup mask. The counter advances on every clock or on a power-of-two prescaled tick. On overflow it either reloads and keeps running, or wraps to zero and halts. A compare unit flags when the count takes the compare value.

Overflow and compare events set status bits, which raise an interrupt line and a wakeup line through their masks. The same events can drive a waveform pin, which either emits one-clock pulses or toggles. Its idle level is programmable.

Run control is a three-state machine. `ST_IDLE` moves to `ST_RUN` once the start bit is set. `ST_RUN` moves to `ST_DRAIN` when the start bit is cleared, and straight to `ST_IDLE` on an overflow without autoreload. `ST_DRAIN` counts for `STOP_LAT` clocks and then moves to `ST_IDLE`. It returns to `ST_RUN` if start is set again, and goes to `ST_IDLE` early on an overflow without autoreload. The counter advances in `ST_RUN` and `ST_DRAIN` only.

Top module: `dm_timer_core`

## Requirements
- R1: After reset the count, status, interrupt, wakeup, waveform pin and run indication are all zero.
- R2: Writing the control word (address 0) with bit 0 set starts counting. With the prescaler off, the count after the m-th clock edge that follows the write edge has grown by m-1. Writing bit 0 as zero requests a stop.
- R3: Control bit 5 enables the prescaler and bits 4:2 hold a ratio n from 0 to 7, so the count advances once per 2^(n+1) clocks. With bit 5 clear it advances on every clock.
- R4: After the edge that clears the start bit, the count advances on that edge and on at most STOP_LAT+1 further edges (3 edges in total at the default). After that it holds and the run indication is low.
- R5: With control bit 1 (autoreload) set, a tick at the all-ones count loads the reload register (address 1) and sets status bit 1.
- R6: With control bit 1 clear, a tick at the all-ones count sets the count to zero, sets status bit 1, clears the start bit and stops the counter.
- R7: With control bit 6 set, a tick that makes the count equal to the compare register (address 3) sets status bit 0. With bit 6 clear, no compare event occurs.
- R8: Control bits 11:10 choose which events drive the waveform pin: 00 none, 01 overflow only, 10 or 11 overflow and compare.
- R9: Control bit 7 is the idle level of the waveform pin. With bit 12 clear, each selected event drives the pin to the opposite level for exactly one clock. With bit 12 set, each selected event inverts the pin.
- R10: Writing the status register (address 5) clears the bits written as one. Bits written as zero are unchanged.
- R11: Writing address 6 sets interrupt enable bits and writing address 7 clears them. The interrupt output is high while any enabled status bit is set. Address 8 holds a wakeup mask with the same bit layout that drives the wakeup output.
- R12: A write of any value to address 4 copies the reload register into the count. A write to address 2 sets the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | active-low reset |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | ADDR_W | register address |
| wr_data_i | input | CNT_W | write data |
| count_o | output | CNT_W | live count |
| status_o | output | 2 | event status, bit 1 overflow, bit 0 compare |
| running_o | output | 1 | high while the counter advances |
| irq_o | output | 1 | interrupt request |
| wake_o | output | 1 | wakeup request |
| pwm_o | output | 1 | event waveform pin |

## Verification
The bench sweeps prescaler ratios, including an interval one clock short of a full period. A divider that is off by one or starts mid-phase shows up there as an extra or missing tick. It measures exactly how far the count moves after a stop request: a core that halts at once, or one that keeps running, lands on a different value. Overflow is driven from just below all-ones both with and without autoreload. Reloading from the wrong source, or failing to halt, gives a wrong count or a high run indication. The waveform tests cover pulse width, toggle persistence, the idle level, overflow-only selection that must ignore compare events, and clearing status with zero bits, which must leave the interrupt asserted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} run_state_t;

    localparam int A_CTRL  = 0;
    localparam int A_LOAD  = 1;
    localparam int A_COUNT = 2;
    localparam int A_MATCH = 3;
    localparam int A_TRIG  = 4;
    localparam int A_STAT  = 5;
    localparam int A_IESET = 6;
    localparam int A_IECLR = 7;
    localparam int A_WAKE  = 8;

    localparam int B_START  = 0;
    localparam int B_AUTO   = 1;
    localparam int B_RAT_LO = 2;
    localparam int B_PRE    = 5;
    localparam int B_CMP    = 6;
    localparam int B_DEF    = 7;
    localparam int B_TRG_LO = 10;
    localparam int B_TGL    = 12;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    localparam int PSC_W = 2 ** RATIO_W;

    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] term;

    // terminal value 2^(n+1)-1: low n+1 bits set
    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            term[i] = (i <= int'(ratio_i));
        end
    end

    assign tick_o = run_i && (!en_i || (psc_q == term));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (!run_i || !en_i || psc_q == term) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end

    // R3
    psc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && en_i && !tick_o) |=> (psc_q == $past(psc_q) + 1'b1));
endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_evt_i,
    input  logic       cmp_evt_i,
    input  logic [1:0] trg_sel_i,
    input  logic       tgl_mode_i,
    input  logic       def_lvl_i,
    output logic       pwm_o
);
    logic trig_evt;
    logic pulse_q;
    logic tgl_q;

    always_comb begin
        unique case (trg_sel_i)
            2'b00:   trig_evt = 1'b0;
            2'b01:   trig_evt = ovf_evt_i;
            default: trig_evt = ovf_evt_i || cmp_evt_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            tgl_q   <= 1'b0;
        end else begin
            pulse_q <= trig_evt && !tgl_mode_i;
            if (trig_evt && tgl_mode_i) begin
                tgl_q <= !tgl_q;
            end
        end
    end

    assign pwm_o = def_lvl_i ^ (tgl_mode_i ? tgl_q : pulse_q);

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && !trig_evt) |=> !pulse_q);
endmodule

// File: rtl/dm_timer_core.sv
module dm_timer_core
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int RATIO_W  = 3,
    parameter int STOP_LAT = 1,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [1:0]        status_o,
    output logic              running_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic              pwm_o
);
    localparam int DR_W = $clog2(STOP_LAT + 1);

    run_state_t state_q, state_d;
    logic [DR_W-1:0]    drain_q;
    logic [CNT_W-1:0]   cnt_q, load_q, match_q, cnt_step;
    logic               start_q, auto_q, pre_q, cmp_q, def_q, tgl_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [1:0]         trg_q;
    logic [1:0]         stat_q, ien_q, wen_q, clr_mask;
    logic               tick, at_max, ovf, cmp_evt, ovf_stop;
    logic wr_ctl, wr_ld, wr_cnt, wr_mt, wr_trg, wr_stt, wr_ies, wr_iec, wr_wk;

    assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
    assign wr_ld  = wr_en_i && (wr_addr_i == ADDR_W'(A_LOAD));
    assign wr_cnt = wr_en_i && (wr_addr_i == ADDR_W'(A_COUNT));
    assign wr_mt  = wr_en_i && (wr_addr_i == ADDR_W'(A_MATCH));
    assign wr_trg = wr_en_i && (wr_addr_i == ADDR_W'(A_TRIG));
    assign wr_stt = wr_en_i && (wr_addr_i == ADDR_W'(A_STAT));
    assign wr_ies = wr_en_i && (wr_addr_i == ADDR_W'(A_IESET));
    assign wr_iec = wr_en_i && (wr_addr_i == ADDR_W'(A_IECLR));
    assign wr_wk  = wr_en_i && (wr_addr_i == ADDR_W'(A_WAKE));

    tmr_prescale #(.RATIO_W(RATIO_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q != ST_IDLE),
        .en_i    (pre_q),
        .ratio_i (ratio_q),
        .tick_o  (tick)
    );

    assign at_max   = &cnt_q;
    assign ovf      = tick && at_max;
    assign ovf_stop = ovf && !auto_q;
    assign cnt_step = at_max ? (auto_q ? load_q : '0) : cnt_q + 1'b1;
    assign cmp_evt  = tick && cmp_q && (cnt_step == match_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            drain_q <= '0;
        end else begin
            state_q <= state_d;
            drain_q <= (state_q == ST_DRAIN) ? drain_q + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_q) state_d = ST_RUN;
            ST_RUN: begin
                if (ovf_stop)     state_d = ST_IDLE;
                else if (!start_q) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ovf_stop)     state_d = ST_IDLE;
                else if (start_q) state_d = ST_RUN;
                else if (drain_q == DR_W'(STOP_LAT - 1)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // control and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0; auto_q <= 1'b0; pre_q <= 1'b0; cmp_q <= 1'b0;
            def_q   <= 1'b0; tgl_q  <= 1'b0; ratio_q <= '0; trg_q <= '0;
            load_q  <= '0;   match_q <= '0;  cnt_q <= '0;
        end else begin
            if (wr_ctl) begin
                start_q <= wr_data_i[B_START];
                auto_q  <= wr_data_i[B_AUTO];
                ratio_q <= wr_data_i[B_RAT_LO +: RATIO_W];
                pre_q   <= wr_data_i[B_PRE];
                cmp_q   <= wr_data_i[B_CMP];
                def_q   <= wr_data_i[B_DEF];
                trg_q   <= wr_data_i[B_TRG_LO +: 2];
                tgl_q   <= wr_data_i[B_TGL];
            end else if (ovf_stop) begin
                start_q <= 1'b0;
            end
            if (wr_ld) load_q  <= wr_data_i;
            if (wr_mt) match_q <= wr_data_i;
            if (wr_cnt)      cnt_q <= wr_data_i;
            else if (wr_trg) cnt_q <= load_q;
            else if (tick)   cnt_q <= cnt_step;
        end
    end

    assign clr_mask = wr_stt ? wr_data_i[1:0] : 2'b00;

    // status and masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0; ien_q <= '0; wen_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | {ovf, cmp_evt};
            if (wr_ies)      ien_q <= ien_q | wr_data_i[1:0];
            else if (wr_iec) ien_q <= ien_q & ~wr_data_i[1:0];
            if (wr_wk) wen_q <= wr_data_i[1:0];
        end
    end

    tmr_outgen u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_evt_i  (ovf),
        .cmp_evt_i  (cmp_evt),
        .trg_sel_i  (trg_q),
        .tgl_mode_i (tgl_q),
        .def_lvl_i  (def_q),
        .pwm_o      (pwm_o)
    );

    assign count_o   = cnt_q;
    assign status_o  = stat_q;
    assign running_o = (state_q != ST_IDLE);
    assign irq_o     = |(stat_q & ien_q);
    assign wake_o    = |(stat_q & wen_q);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !wr_trg && !ovf) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_cnt && !wr_trg) |=> $stable(cnt_q));
    // R4
    drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (int'(drain_q) < STOP_LAT));
    // R10
    stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[1]) |-> $past(wr_stt && wr_data_i[1]));
    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q != 2'b00));
endmodule

// File: tb/sim_dm_timer_core.sv
module sim_dm_timer_core;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] count;
    logic [1:0]  status;
    logic        running, irq, wake, pwm;

    int n_chk = 0;
    int n_bad = 0;

    // prescaler table: pre_en, ratio, edges after start, expected count (R3)
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{0, 0, 10, 10}, '{1, 0, 10, 5}, '{1, 1, 3, 0}, '{1, 1, 12, 3},
        '{1, 2, 17, 2},  '{1, 3, 16, 1}, '{1, 7, 600, 2}
    };

    always #(PER/2) clk = ~clk;

    dm_timer_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .count_o(count), .status_o(status),
        .running_o(running), .irq_o(irq), .wake_o(wake), .pwm_o(pwm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic halt_clear;
        wr(0, 32'h0);
        cycles(4);
        wr(2, 32'h0);
        wr(5, 32'h3);
    endtask

    initial begin
        #(PER * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] c;
        int hi;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1
        check("R1 count", count, 0);
        check("R1 status", 32'(status), 0);
        check("R1 flags", {28'h0, running, irq, wake, pwm}, 0);

        // R3 table walk
        for (int i = 0; i < NV; i++) begin
            halt_clear();
            wr(0, 32'(1 | (VEC[i][0] << 5) | (VEC[i][1] << 2)));
            cycles(1 + VEC[i][2]);
            check("R3 prescaled count", count, 32'(VEC[i][3]));
        end

        // R2 and R4: start then stop latency
        halt_clear();
        wr(0, 32'h1);
        cycles(5);
        check("R2 run count", count, 4);
        c = count;
        wr(0, 32'h0);
        cycles(6);
        check("R4 stopped count", count, c + 3);
        check("R4 running low", 32'(running), 0);
        cycles(5);
        check("R4 held count", count, c + 3);

        // R12
        wr(1, 32'h1234);
        wr(4, 32'hdead);
        check("R12 trigger reload", count, 32'h1234);
        wr(2, 32'h55);
        check("R12 direct count", count, 32'h55);

        // R5 overflow with autoreload, R11 and R10
        wr(1, 32'h100);
        wr(2, 32'hFFFF_FFFD);
        wr(0, 32'h3);
        cycles(4);
        check("R5 reload value", count, 32'h100);
        check("R5 overflow status", 32'(status), 2);
        check("R5 still running", 32'(running), 1);
        check("R11 irq masked", 32'(irq), 0);
        wr(6, 32'h2);
        check("R11 irq enabled", 32'(irq), 1);
        wr(8, 32'h2);
        check("R11 wake enabled", 32'(wake), 1);
        wr(5, 32'h0);
        check("R10 zero write keeps", 32'(status), 2);
        check("R10 irq kept", 32'(irq), 1);
        wr(5, 32'h2);
        check("R10 cleared", 32'(status), 0);
        check("R11 irq dropped", {30'h0, irq, wake}, 0);
        wr(7, 32'h2);
        wr(8, 32'h0);
        halt_clear();

        // R6 overflow without autoreload
        wr(2, 32'hFFFF_FFFE);
        wr(0, 32'h1);
        cycles(4);
        check("R6 wrapped count", count, 0);
        check("R6 halted", 32'(running), 0);
        check("R6 overflow status", 32'(status), 2);
        cycles(3);
        check("R6 stays zero", count, 0);
        halt_clear();

        // R7 R8 R9 pulse on compare, select 10
        wr(3, 32'h5);
        wr(0, 32'h841);
        cycles(5);
        check("R9 pulse before", {count[30:0], pwm}, {31'd4, 1'b0});
        cycles(1);
        check("R9 pulse high", {count[30:0], pwm}, {31'd5, 1'b1});
        check("R7 compare status", 32'(status), 1);
        cycles(1);
        check("R9 pulse one clock", 32'(pwm), 0);
        halt_clear();

        // R8 overflow-only selection ignores compare
        wr(0, 32'h441);
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            cycles(1);
            if (pwm) hi++;
        end
        check("R8 no pin activity", 32'(hi), 0);
        check("R8 compare still flagged", 32'(status), 1);
        halt_clear();

        // R7 compare disabled
        wr(0, 32'h801);
        hi = 0;
        for (int k = 0; k < 8; k++) begin
            cycles(1);
            if (pwm) hi++;
        end
        check("R7 no compare status", 32'(status), 0);
        check("R7 no pin activity", 32'(hi), 0);
        halt_clear();

        // R9 toggle mode with idle level high
        wr(3, 32'h3);
        wr(0, 32'h18C0);
        check("R9 idle level", 32'(pwm), 1);
        wr(0, 32'h18C1);
        cycles(3);
        check("R9 before toggle", {count[30:0], pwm}, {31'd2, 1'b1});
        cycles(1);
        check("R9 toggled", {count[30:0], pwm}, {31'd3, 1'b0});
        cycles(3);
        check("R9 toggle holds", 32'(pwm), 0);
        halt_clear();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule